// File: doc/BRIEF.md
# Armed-Fire Actuator Pulse Controller

This block energizes one of several actuator switches under software control, using a two-step handshake so that a single stray write can never turn a switch on. Software first names an actuator and arms it, then issues a fire command for that same actuator. The selected drive line then stays on for a programmed time, set in sixteenths of a second, or stays on until told to stop when the hold option is set.

A disarm/abort command drops any armed or driven state at once. An arm that is not followed by a fire within one second lapses. Every command that arrives at the wrong moment is refused and raises a sticky error bit, which software clears with a dedicated command. Optocoupled feedback lines are synchronized and readable as a status word. One channel has no feedback line and always reads as 0.

Top module: `act_ctrl`

## Requirements
- R1: After reset all drive outputs are 0, the state field reads idle (0), the error bit reads 0 and the stored duration code reads 0.
- R2: Register 0 (write and read) holds the duration code in bits [8:0] and the hold flag in bit 15. Register 1 (write) is the command: bits [1:0] give the operation (0 clear error, 1 arm, 2 fire, 3 abort) and bits [10:8] give the actuator address. Register 1 (read) gives the error in bit 15, the state in bits [9:8] (0 idle, 1 armed, 2 firing) and the last armed address in bits [2:0]. Register 2 (read) gives the feedback status, one bit per channel.
- R3: A fire command whose address equals the armed address moves the state from armed to firing and drives only the output bit of that address, starting on the clock edge that takes the command.
- R4: Without hold, the output stays on for exactly max(10, min(code, 256)) × TICK_DIV clock cycles, one unit of TICK_DIV cycles standing for 1/16 s, and then the state returns to idle.
- R5: With the hold flag set at fire time, the output stays on until an abort command.
- R6: A fire command in idle, a fire command whose address differs from the armed address, and an arm or fire command during firing are all refused and set the error bit. A refused fire in armed returns the state to idle and drives nothing.
- R7: An abort command in armed or firing returns the state to idle, and the drive outputs are 0 from the next clock edge.
- R8: The armed state returns to idle by itself after 16 × TICK_DIV cycles (1 s) without a fire command.
- R9: At most one drive output is on at any time, and only in the firing state.
- R10: Each feedback input shows in register 2 within three clock cycles of a change. The channel NOFB_CH always reads 0.
- R11: Command operation 0 clears the error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | 16 | Read data (combinational from stored state) |
| fb_in | input | N_ACT | Asynchronous feedback lines |
| drive | output | N_ACT | Actuator switch enables |

## Verification
Random arm-and-fire sequences over every address and over duration codes from 0 to 300 separate the clamping at the low end, the clamping at the high end and plain scaling by the measured on-time. They also show the decoded address by the single output bit that turns on. Directed cases set fire-without-arm, mismatched addresses, commands during firing and the one-second arm lapse against each other, so that refused commands show as a raised error bit with no drive. Random feedback words, including the bit of the channel without feedback, check the synchronizer and the forced-zero channel.

// File: rtl/act_pkg.sv
package act_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } act_state_e;

    typedef enum logic [1:0] {
        OP_CLR   = 2'd0,
        OP_ARM   = 2'd1,
        OP_FIRE  = 2'd2,
        OP_ABORT = 2'd3
    } act_op_e;

    localparam int CODE_W   = 9;
    localparam int CODE_MIN = 10;
    localparam int CODE_MAX = 256;
    localparam int ARM_WIN  = 16;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
        if (c < CODE_W'(CODE_MIN))      return CODE_W'(CODE_MIN);
        else if (c > CODE_W'(CODE_MAX)) return CODE_W'(CODE_MAX);
        else                            return c;
    endfunction
endpackage

// File: rtl/act_sync.sv
module act_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/act_interval.sv
module act_interval
    import act_pkg::*;
#(
    parameter int TICK_DIV = 1048576
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [CODE_W-1:0] len,
    output logic              expire
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0]     pre;
        logic [CODE_W-1:0] six;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.pre = PRE_TOP;
            tmr_d.six = len - CODE_W'(1);
        end else if (run) begin
            if (tmr_q.pre == '0) begin
                if (tmr_q.six != '0) begin
                    tmr_d.six = tmr_q.six - CODE_W'(1);
                    tmr_d.pre = PRE_TOP;
                end
            end else begin
                tmr_d.pre = tmr_q.pre - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire = run && (tmr_q.pre == '0) && (tmr_q.six == '0);
endmodule

// File: rtl/act_ctrl.sv
module act_ctrl
    import act_pkg::*;
#(
    parameter int N_ACT    = 8,
    parameter int NOFB_CH  = 7,
    parameter int TICK_DIV = 1048576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [15:0]      rd_data,
    input  logic [N_ACT-1:0] fb_in,
    output logic [N_ACT-1:0] drive
);
    localparam int AW = (N_ACT > 1) ? $clog2(N_ACT) : 1;

    typedef struct packed {
        act_state_e        state;
        logic [AW-1:0]     arm_addr;
        logic              err;
        logic              hold_cfg;
        logic [CODE_W-1:0] code;
        logic              hold;
        logic [N_ACT-1:0]  drv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tmr_start, tmr_run, tmr_exp;
    logic [CODE_W-1:0] tmr_len;
    logic [N_ACT-1:0]  fb_sync, fb_stat;

    logic          cmd_wr, cfg_wr;
    act_op_e       op;
    logic [AW-1:0] op_addr;

    assign cmd_wr  = wr_en && (wr_addr == 2'd1);
    assign cfg_wr  = wr_en && (wr_addr == 2'd0);
    assign op      = act_op_e'(wr_data[1:0]);
    assign op_addr = wr_data[8+AW-1:8];

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_len   = CODE_W'(ARM_WIN);
        if (cfg_wr) begin
            ctl_d.code     = wr_data[CODE_W-1:0];
            ctl_d.hold_cfg = wr_data[15];
        end
        if (cmd_wr && op == OP_CLR) ctl_d.err = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_wr && op == OP_ARM) begin
                    ctl_d.state    = ST_ARMED;
                    ctl_d.arm_addr = op_addr;
                    tmr_start      = 1'b1;
                end else if (cmd_wr && op == OP_FIRE) begin
                    ctl_d.err = 1'b1;
                end
            end
            ST_ARMED: begin
                if (cmd_wr && op == OP_FIRE) begin
                    if (op_addr == ctl_q.arm_addr) begin
                        ctl_d.state = ST_FIRE;
                        ctl_d.hold  = ctl_q.hold_cfg;
                        ctl_d.drv   = N_ACT'(1) << op_addr;
                        tmr_len     = clamp_code(ctl_q.code);
                        tmr_start   = 1'b1;
                    end else begin
                        ctl_d.err   = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end
                end else if (cmd_wr && op == OP_ARM) begin
                    ctl_d.arm_addr = op_addr;
                    tmr_start      = 1'b1;
                end else if (cmd_wr && op == OP_ABORT) begin
                    ctl_d.state = ST_IDLE;
                end else if (tmr_exp) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_FIRE: begin
                if (cmd_wr && op == OP_ABORT) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.drv   = '0;
                end else if (cmd_wr && (op == OP_ARM || op == OP_FIRE)) begin
                    ctl_d.err = 1'b1;
                end else if (tmr_exp) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.drv   = '0;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.drv   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign tmr_run = (ctl_q.state == ST_ARMED) ||
                     (ctl_q.state == ST_FIRE && !ctl_q.hold);

    act_interval #(.TICK_DIV(TICK_DIV)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    act_sync #(.W(N_ACT)) u_fb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fb_in),
        .sync_out (fb_sync)
    );

    for (genvar i = 0; i < N_ACT; i++) begin : g_fb
        if (i == NOFB_CH) begin : g_none
            assign fb_stat[i] = 1'b0;
        end else begin : g_live
            assign fb_stat[i] = fb_sync[i];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            2'd0: begin
                rd_data[CODE_W-1:0] = ctl_q.code;
                rd_data[15]         = ctl_q.hold_cfg;
            end
            2'd1: begin
                rd_data[15]     = ctl_q.err;
                rd_data[9:8]    = ctl_q.state;
                rd_data[AW-1:0] = ctl_q.arm_addr;
            end
            2'd2:    rd_data[N_ACT-1:0] = fb_stat;
            default: rd_data = '0;
        endcase
    end

    assign drive = ctl_q.drv;

    logic [1:0] cur_state;
    logic       cur_err;
    assign cur_state = ctl_q.state;
    assign cur_err   = ctl_q.err;
endmodule

// File: rtl/act_ctrl_chk.sv
module act_ctrl_chk #(
    parameter int N_ACT   = 8,
    parameter int NOFB_CH = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [15:0]      wr_data,
    input logic [1:0]       rd_addr,
    input logic [15:0]      rd_data,
    input logic [N_ACT-1:0] drive,
    input logic [1:0]       cur_state,
    input logic             cur_err
);
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive));

    a_r9_drive_only_firing: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != '0) |-> (cur_state == 2'd2));

    a_r3_fire_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == 2'd2 && $past(cur_state) != 2'd2) |-> ($past(cur_state) == 2'd1));

    a_r7_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data[1:0] == 2'd3) |=> (drive == '0));

    a_r6_err_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_err) |-> $past(wr_en && wr_addr == 2'd1));

    a_r10_nofb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd2) |-> (rd_data[NOFB_CH] == 1'b0));
endmodule

bind act_ctrl act_ctrl_chk #(.N_ACT(N_ACT), .NOFB_CH(NOFB_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .drive     (drive),
    .cur_state (cur_state),
    .cur_err   (cur_err)
);

// File: tb/act_ctrl_bench.sv
`timescale 1ns/1ps
module act_ctrl_bench;
    localparam int N  = 8;
    localparam int NF = 7;
    localparam int TD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [N-1:0] fb_in = '0;
    logic [N-1:0] drive;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    act_ctrl #(.N_ACT(N), .NOFB_CH(NF), .TICK_DIV(TD)) u_act_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fb_in(fb_in), .drive(drive)
    );

    function automatic int exp_len(input int code);
        int c = code;
        if (c < 10)  c = 10;
        if (c > 256) c = 256;
        return c * TD;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input int op, input int addr);
        wr(2'd1, 16'((addr << 8) | op));
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int f_state(input logic [15:0] s); return int'(s[9:8]); endfunction

    initial begin
        logic [15:0] s;
        int cnt;
        logic [N-1:0] seen;
        void'($urandom(32'd1234));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        check("R1 drive", drive, 0);
        rd(2'd1, s);
        check("R1 state", f_state(s), 0);
        check("R1 err", s[15], 0);
        rd(2'd0, s);
        check("R1 code", s, 0);

        // R2 config readback
        wr(2'd0, 16'h8123);
        rd(2'd0, s);
        check("R2 cfg readback", s, 16'h8123);
        wr(2'd0, 16'h0000);

        // R6 fire in idle
        cmd(2, 3);
        rd(2'd1, s);
        check("R6 idle fire err", s[15], 1);
        check("R6 idle fire drive", drive, 0);
        // R11 clear
        cmd(0, 0);
        rd(2'd1, s);
        check("R11 clear err", s[15], 0);

        // R6 mismatch fire
        cmd(1, 2);
        rd(2'd1, s);
        check("R2 armed state", f_state(s), 1);
        check("R2 armed addr", s[2:0], 2);
        cmd(2, 5);
        rd(2'd1, s);
        check("R6 mismatch err", s[15], 1);
        check("R6 mismatch state", f_state(s), 0);
        check("R6 mismatch drive", drive, 0);
        cmd(0, 0);

        // R8 arm timeout
        cmd(1, 4);
        wait_cyc(62);
        rd(2'd1, s);
        check("R8 still armed", f_state(s), 1);
        wait_cyc(2);
        rd(2'd1, s);
        check("R8 lapsed", f_state(s), 0);
        cmd(2, 4);
        check("R8 late fire drive", drive, 0);
        rd(2'd1, s);
        check("R8 late fire err", s[15], 1);
        cmd(0, 0);

        // R7 abort in armed
        cmd(1, 1);
        cmd(3, 0);
        rd(2'd1, s);
        check("R7 abort armed", f_state(s), 0);

        // R5 hold, R6 commands in firing, R7 abort firing
        wr(2'd0, 16'h8000 | 16'd10);
        cmd(1, 6);
        cmd(2, 6);
        wait_cyc(300);
        check("R5 hold drive", drive, 8'h40);
        cmd(1, 2);
        rd(2'd1, s);
        check("R6 arm during fire err", s[15], 1);
        check("R6 arm during fire state", f_state(s), 2);
        check("R6 arm during fire drive", drive, 8'h40);
        cmd(0, 0);
        cmd(3, 0);
        check("R7 abort firing drive", drive, 0);
        rd(2'd1, s);
        check("R7 abort firing state", f_state(s), 0);

        // R3/R4 directed boundaries plus random trials
        for (int t = 0; t < 24; t++) begin
            int code, addr;
            if (t == 0)      code = 0;
            else if (t == 1) code = 9;
            else if (t == 2) code = 10;
            else if (t == 3) code = 256;
            else if (t == 4) code = 257;
            else             code = int'($urandom_range(0, 300));
            addr = int'($urandom_range(0, N - 1));
            wr(2'd0, 16'(code));
            cmd(1, addr);
            wait_cyc(int'($urandom_range(0, 40)));
            cmd(2, addr);
            check("R3 decoded drive", drive, 1 << addr);
            cnt = 0;
            seen = '0;
            while (drive != '0 && cnt < 5000) begin
                seen |= drive;
                cnt++;
                @(negedge clk);
            end
            check("R4 on-time", cnt, exp_len(code));
            check("R9 single bit", seen, 1 << addr);
            rd(2'd1, s);
            check("R4 back to idle", f_state(s), 0);
        end

        // R10 feedback
        for (int t = 0; t < 10; t++) begin
            logic [N-1:0] v;
            v = N'($urandom());
            if (t == 0) v = '1;
            fb_in = v;
            wait_cyc(3);
            rd(2'd2, s);
            check("R10 feedback", s[N-1:0], v & ~(N'(1) << NF));
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule